// File: doc/BRIEF.md
# Aspect-Ratio Compander Line FIFO

This block is the line store behind horizontal picture compression and expansion. Serial video bits arrive under a write strobe at the source rate. They leave under a read strobe whose density differs from the write strobe's. When reads are sparser than writes, the stored line is stretched across the output, which gives expansion. When reads are denser, the line is squeezed, which gives compression. The ratio itself is chosen outside the block. Both sides share one clock, and rate conversion is expressed purely through how often each enable is raised.

Storage is 5264 bits, held as 188 words of 28 bits, and each word holds seven 4-bit groups. A write-side gatherer packs four consecutive serial bits into a group before that group is written to the array. A read-side shifter takes one group from the array and hands it out bit by bit. The array therefore sees at most one access per side for every four serial bits. An independent write pointer and read pointer each address a word and a group slot within it. A line-start pulse returns the block to its empty state at the beginning of every video line.

Top module: `compander_fifo`

## Requirements
- R1: After `rst_ni` low or a `line_start_i` pulse, `empty_o`=1, `full_o`=0, `rd_valid_o`=0 and `rd_bit_o`=0, and no bit written before that point is ever read out afterwards.
- R2: Bits leave on `rd_bit_o` in exactly the order in which they were accepted. An accepted read on `rd_en_i` shows its bit on `rd_bit_o`, with `rd_valid_o`=1, in the cycle after the strobe.
- R3: Written bits become readable only as complete groups of four. `empty_o` is 1 whenever no whole group is stored and the read shifter holds no remaining bits. A read is accepted only when `empty_o` is 0.
- R4: `full_o` is 1 exactly when 1316 groups (5264 bits) are stored unread. `full_o` and `empty_o` are never 1 together.
- R5: A write strobe while `full_o`=1 is dropped: its bit never appears in the output stream and the flags do not change because of it.
- R6: A read strobe while `empty_o`=1 is ignored: `rd_valid_o` stays 0 and `rd_bit_o` keeps its previous value.
- R7: The bit order is preserved both when reads are sparser than writes (expansion) and when they are denser (compression), including across pointer wrap-around past word 187.
- R8: `line_start_i` takes priority over `wr_en_i` and `rd_en_i` in the same cycle: neither strobe is acted on in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Single clock for both sides |
| rst_ni | input | 1 | Synchronous reset, active low |
| line_start_i | input | 1 | Clears pointers, gatherer and shifter at line start |
| wr_en_i | input | 1 | Write strobe: one serial bit offered |
| wr_bit_i | input | 1 | Serial write bit |
| rd_en_i | input | 1 | Read strobe: one serial bit requested |
| rd_bit_o | output | 1 | Serial read bit, registered |
| rd_valid_o | output | 1 | High in the cycle after an accepted read |
| full_o | output | 1 | All group slots hold unread data |
| empty_o | output | 1 | No readable bit is available |

## Verification
If a pointer, the group count or the gatherer or shifter position goes wrong, the serial output stream shows it. A misplaced slot or a skipped group corrupts or reorders bits, and this appears within one group of four reads once the affected data reaches the read side. A wrong count shows first at the flags, as `empty_o` or `full_o` switching one group too early or too late near the boundaries. Streams that run past the array end also expose wrap-around errors, which would otherwise stay hidden until the second pass through the array.

// File: rtl/compander_pkg.sv
package compander_pkg;
    localparam int NIB_W = 4;
    localparam int CNT_W = $clog2(NIB_W);

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        nib_t             data;
        logic [CNT_W-1:0] cnt;
    } gather_s;

    typedef struct packed {
        nib_t             data;
        logic [CNT_W-1:0] left;
        logic             out_bit;
        logic             valid;
    } shift_s;
endpackage

// File: rtl/compander_gather.sv
module compander_gather
    import compander_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic bit_en_i,
    input  logic bit_i,
    output nib_t nib_o,
    output logic commit_o
);
    gather_s g_d, g_q;
    nib_t    merged;

    always_comb begin
        g_d            = g_q;
        merged         = g_q.data;
        merged[g_q.cnt] = bit_i;
        commit_o       = 1'b0;
        if (clear_i) begin
            g_d = '0;
        end else if (bit_en_i) begin
            g_d.data = merged;
            if (g_q.cnt == CNT_W'(NIB_W - 1)) begin
                g_d.cnt  = '0;
                commit_o = 1'b1;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end
    end

    assign nib_o = merged;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) g_q <= '0;
        else         g_q <= g_d;
    end
endmodule

// File: rtl/compander_shift.sv
module compander_shift
    import compander_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic rd_en_i,
    input  logic have_nib_i,
    input  nib_t mem_nib_i,
    output logic take_o,
    output logic has_bits_o,
    output logic rd_bit_o,
    output logic rd_valid_o
);
    shift_s s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        take_o    = 1'b0;
        if (clear_i) begin
            s_d = '0;
        end else if (rd_en_i) begin
            if (s_q.left != '0) begin
                s_d.out_bit = s_q.data[0];
                s_d.data    = s_q.data >> 1;
                s_d.left    = s_q.left - 1'b1;
                s_d.valid   = 1'b1;
            end else if (have_nib_i) begin
                take_o      = 1'b1;
                s_d.out_bit = mem_nib_i[0];
                s_d.data    = mem_nib_i >> 1;
                s_d.left    = CNT_W'(NIB_W - 1);
                s_d.valid   = 1'b1;
            end
        end
    end

    assign has_bits_o = (s_q.left != '0);
    assign rd_bit_o   = s_q.out_bit;
    assign rd_valid_o = s_q.valid;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end
endmodule

// File: rtl/compander_ptr.sv
module compander_ptr #(
    parameter  int DEPTH = 188,
    parameter  int SLOTS = 7,
    localparam int CAP   = DEPTH * SLOTS,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(SLOTS),
    localparam int CW    = $clog2(CAP + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] wr_word_o,
    output logic [SW-1:0] wr_slot_o,
    output logic [AW-1:0] rd_word_o,
    output logic [SW-1:0] rd_slot_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          none_o
);
    typedef struct packed {
        logic [AW-1:0] wr_word;
        logic [SW-1:0] wr_slot;
        logic [AW-1:0] rd_word;
        logic [SW-1:0] rd_slot;
        logic [CW-1:0] count;
    } ptr_s;

    ptr_s p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (clear_i) begin
            p_d = '0;
        end else begin
            if (push_i) begin
                if (p_q.wr_slot == SW'(SLOTS - 1)) begin
                    p_d.wr_slot = '0;
                    p_d.wr_word = (p_q.wr_word == AW'(DEPTH - 1)) ? '0 : p_q.wr_word + 1'b1;
                end else begin
                    p_d.wr_slot = p_q.wr_slot + 1'b1;
                end
            end
            if (pop_i) begin
                if (p_q.rd_slot == SW'(SLOTS - 1)) begin
                    p_d.rd_slot = '0;
                    p_d.rd_word = (p_q.rd_word == AW'(DEPTH - 1)) ? '0 : p_q.rd_word + 1'b1;
                end else begin
                    p_d.rd_slot = p_q.rd_slot + 1'b1;
                end
            end
            case ({push_i, pop_i})
                2'b10:   p_d.count = p_q.count + 1'b1;
                2'b01:   p_d.count = p_q.count - 1'b1;
                default: p_d.count = p_q.count;
            endcase
        end
    end

    assign wr_word_o = p_q.wr_word;
    assign wr_slot_o = p_q.wr_slot;
    assign rd_word_o = p_q.rd_word;
    assign rd_slot_o = p_q.rd_slot;
    assign count_o   = p_q.count;
    assign full_o    = (p_q.count == CW'(CAP));
    assign none_o    = (p_q.count == '0);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end
endmodule

// File: rtl/compander_store.sv
module compander_store
    import compander_pkg::*;
#(
    parameter  int DEPTH  = 188,
    parameter  int WORD_W = 28,
    localparam int SLOTS  = WORD_W / NIB_W,
    localparam int AW     = $clog2(DEPTH),
    localparam int SW     = $clog2(SLOTS)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] wr_word_i,
    input  logic [SW-1:0] wr_slot_i,
    input  nib_t          nib_i,
    input  logic [AW-1:0] rd_word_i,
    input  logic [SW-1:0] rd_slot_i,
    output nib_t          nib_o
);
    logic [WORD_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) cells_q[wr_word_i][32'(wr_slot_i) * NIB_W +: NIB_W] <= nib_i;
    end

    assign nib_o = cells_q[rd_word_i][32'(rd_slot_i) * NIB_W +: NIB_W];
endmodule

// File: rtl/compander_fifo.sv
module compander_fifo
    import compander_pkg::*;
#(
    parameter int DEPTH  = 188,
    parameter int WORD_W = 28
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_start_i,
    input  logic wr_en_i,
    input  logic wr_bit_i,
    input  logic rd_en_i,
    output logic rd_bit_o,
    output logic rd_valid_o,
    output logic full_o,
    output logic empty_o
);
    localparam int SLOTS = WORD_W / NIB_W;
    localparam int CAP   = DEPTH * SLOTS;
    localparam int AW    = $clog2(DEPTH);
    localparam int SW    = $clog2(SLOTS);
    localparam int CW    = $clog2(CAP + 1);

    logic          wr_accept, commit, take, has_bits, none;
    nib_t          wr_nib, rd_nib;
    logic [AW-1:0] wr_word, rd_word;
    logic [SW-1:0] wr_slot, rd_slot;
    logic [CW-1:0] nib_count;

    assign wr_accept = wr_en_i & ~full_o & ~line_start_i;

    compander_gather u_gather (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (line_start_i),
        .bit_en_i (wr_accept),
        .bit_i    (wr_bit_i),
        .nib_o    (wr_nib),
        .commit_o (commit)
    );

    compander_ptr #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_ptr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (line_start_i),
        .push_i    (commit),
        .pop_i     (take),
        .wr_word_o (wr_word),
        .wr_slot_o (wr_slot),
        .rd_word_o (rd_word),
        .rd_slot_o (rd_slot),
        .count_o   (nib_count),
        .full_o    (full_o),
        .none_o    (none)
    );

    compander_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk_i     (clk_i),
        .we_i      (commit),
        .wr_word_i (wr_word),
        .wr_slot_i (wr_slot),
        .nib_i     (wr_nib),
        .rd_word_i (rd_word),
        .rd_slot_i (rd_slot),
        .nib_o     (rd_nib)
    );

    compander_shift u_shift (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (line_start_i),
        .rd_en_i    (rd_en_i),
        .have_nib_i (~none),
        .mem_nib_i  (rd_nib),
        .take_o     (take),
        .has_bits_o (has_bits),
        .rd_bit_o   (rd_bit_o),
        .rd_valid_o (rd_valid_o)
    );

    assign empty_o = none & ~has_bits;
endmodule

// File: rtl/compander_fifo_chk.sv
module compander_fifo_chk #(
    parameter int CAP = 1316,
    parameter int CW  = 11
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          line_start_i,
    input logic          wr_en_i,
    input logic          rd_en_i,
    input logic          rd_bit_o,
    input logic          rd_valid_o,
    input logic          full_o,
    input logic          empty_o,
    input logic [CW-1:0] count_i
);
    // R4
    no_full_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(full_o && empty_o));

    // R4
    count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_i <= CW'(CAP));

    // R6
    empty_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && empty_o && !line_start_i) |=> (!rd_valid_o && $stable(rd_bit_o)));

    // R5
    full_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && wr_en_i && !rd_en_i && !line_start_i) |=> (full_o && $stable(count_i)));

    // R8
    line_start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_start_i |=> (empty_o && !full_o && !rd_valid_o && !rd_bit_o));

    // R2
    valid_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rd_valid_o);
endmodule

bind compander_fifo compander_fifo_chk #(.CAP(CAP), .CW(CW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .rd_bit_o     (rd_bit_o),
    .rd_valid_o   (rd_valid_o),
    .full_o       (full_o),
    .empty_o      (empty_o),
    .count_i      (nib_count)
);

// File: tb/tb_compander_fifo.sv
`timescale 1ns/1ps
module tb_compander_fifo;
    localparam int CAP = 188 * 7;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic line_start = 1'b0, wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
    logic rd_bit, rd_valid, full, empty;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    // reference model state
    int   m_pack = 0, m_nib = 0, m_left = 0;
    logic last_bit = 1'b0;
    logic q_bits[$];

    always #5 clk = ~clk;

    compander_fifo dut (
        .clk_i(clk), .rst_ni(rst_ni), .line_start_i(line_start),
        .wr_en_i(wr_en), .wr_bit_i(wr_bit), .rd_en_i(rd_en),
        .rd_bit_o(rd_bit), .rd_valid_o(rd_valid), .full_o(full), .empty_o(empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_empty();
        return (m_nib == 0) && (m_left == 0);
    endfunction

    // one cycle: drive at negedge, model, sample at the next negedge
    task automatic step(input logic w, input logic b, input logic r, input logic ls, input string req);
        logic exp_valid, exp_bit;
        bit   rd_ok, wr_ok;
        wr_en = w; wr_bit = b; rd_en = r; line_start = ls;
        exp_valid = 1'b0;
        exp_bit   = last_bit;
        if (ls) begin
            m_pack = 0; m_nib = 0; m_left = 0;
            q_bits.delete();
            exp_bit = 1'b0;
        end else begin
            rd_ok = r && !m_empty();
            wr_ok = w && (m_nib != CAP);
            if (rd_ok) begin
                exp_valid = 1'b1;
                exp_bit   = q_bits.pop_front();
                if (m_left == 0) begin m_nib--; m_left = 3; end
                else m_left--;
            end
            if (wr_ok) begin
                q_bits.push_back(b);
                if (m_pack == 3) begin m_pack = 0; m_nib++; end
                else m_pack++;
            end
        end
        last_bit = exp_bit;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; line_start = 1'b0;
        check(rd_valid == exp_valid, {req, " rd_valid"}, int'(rd_valid), int'(exp_valid));
        check(rd_bit == exp_bit, {req, " rd_bit"}, int'(rd_bit), int'(exp_bit));
        check(full == (m_nib == CAP), {req, " full"}, int'(full), int'(m_nib == CAP));
        check(empty == m_empty(), {req, " empty"}, int'(empty), int'(m_empty()));
    endtask

    task automatic drain(input string req);
        while (!m_empty()) step(1'b0, 1'b0, 1'b1, 1'b0, req);
    endtask

    task automatic t_reset();
        check(empty == 1'b1, "R1 reset empty", int'(empty), 1);
        check(full == 1'b0, "R1 reset full", int'(full), 0);
        check(rd_valid == 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
        check(rd_bit == 1'b0, "R1 reset rd_bit", int'(rd_bit), 0);
    endtask

    task automatic t_partial_group();
        step(1'b1, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R3");
        check(empty == 1'b1, "R3 three bits not readable", int'(empty), 1);
        step(1'b1, 1'b1, 1'b0, 1'b0, "R3");
        check(empty == 1'b0, "R3 group complete", int'(empty), 0);
        drain("R2");
    endtask

    task automatic t_empty_read();
        step(1'b1, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R6");
        drain("R6");
        check(rd_bit == 1'b1, "R6 last bit before empty reads", int'(rd_bit), 1);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
        check(rd_bit == 1'b1, "R6 rd_bit held", int'(rd_bit), 1);
    endtask

    task automatic t_expand();
        for (int i = 0; i < 900; i++)
            step(1'b1, 1'($urandom()), (i % 3) != 0, 1'b0, "R7 expand");
        drain("R7 expand");
    endtask

    task automatic t_compress();
        for (int i = 0; i < 240; i++) step(1'b1, 1'($urandom()), 1'b0, 1'b0, "R7 compress");
        for (int i = 0; i < 900; i++)
            step((i % 3) != 0, 1'($urandom()), 1'b1, 1'b0, "R7 compress");
        drain("R7 compress");
    endtask

    task automatic t_full();
        step(1'b0, 1'b0, 1'b0, 1'b1, "R1");
        for (int i = 0; i < CAP * 4; i++) step(1'b1, 1'(i % 3 == 0), 1'b0, 1'b0, "R4");
        check(full == 1'b1, "R4 full after 5264 bits", int'(full), 1);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R5");
        check(full == 1'b1, "R5 still full after dropped writes", int'(full), 1);
        step(1'b0, 1'b0, 1'b1, 1'b0, "R4");
        check(full == 1'b0, "R4 full clears after read", int'(full), 0);
        drain("R5");
        for (int i = 0; i < 1200; i++)
            step(1'b1, 1'($urandom()), (i % 2) == 0, 1'b0, "R7 wrap");
        drain("R7 wrap");
    endtask

    task automatic t_line_start();
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, i > 10, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R8");
        check(empty == 1'b1, "R8 line start wins", int'(empty), 1);
        check(rd_bit == 1'b0, "R1 rd_bit cleared", int'(rd_bit), 0);
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        drain("R1 fresh data");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk);
        t_partial_group();
        t_empty_read();
        t_expand();
        t_compress();
        t_full();
        t_line_start();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
        $finish;
    end
endmodule